// File: doc/BRIEF.md
# Invariant CRC Generator for Routable RDMA Packets

This block computes the 32-bit invariant CRC that a routable RDMA-over-Ethernet packet carried in UDP over IPv4 must hold at the end of its UDP payload. Frames enter on a wide AXI4-Stream slave port, with byte 0 of the frame in `s_tdata[7:0]`, and the stream starts at the Ethernet header. The block drops the 14-byte Ethernet header and folds eight 0xFF bytes in ahead of the IP header, standing in for a link header. It forces the fields that routers may rewrite to 0xFF and then folds every kept byte into a CRC-32. The port never stalls, so a new beat can arrive on every clock.

A small frame state machine tracks whether the next beat opens a frame. It has two states. `ST_IDLE` means the next beat is the first of a frame. `ST_BODY` means a frame is under way. There are three transitions. START goes from `ST_IDLE` to `ST_BODY` when a beat without `s_tlast` is accepted. SINGLE stays in `ST_IDLE` when a beat with `s_tlast` is accepted. END goes from `ST_BODY` to `ST_IDLE` when a beat with `s_tlast` is accepted. Every beat passes through three registered stages: byte masking, CRC accumulation and the result register. A last beat whose keep pattern is malformed raises an error strobe, and no CRC is given for that frame.

Top module: `icrc_gen`

## Requirements
- R1: While reset is asserted and on the first clock edges after it, `crc_valid` and `crc_error` are low. From the second rising edge after reset is released, `s_tready` is high.
- R2: `s_tready` stays high outside reset, so a beat is taken on every cycle that `s_tvalid` is high. Frames may follow each other with no idle cycle between them.
- R3: The CRC is CRC-32 with the reflected polynomial 0xEDB88320 and initial value 0xFFFFFFFF. Each byte is folded in least significant bit first, and the result is inverted. Bytes are folded in stream order: beat by beat, and within a beat from `s_tdata[7:0]` upward.
- R4: Frame bytes 0 to 13 (the Ethernet header) do not affect the result.
- R5: Eight bytes of 0xFF are folded in before frame byte 14.
- R6: Frame bytes 15, 22, 24, 25, 40, 41 and 46 are folded in as 0xFF whatever their value. These are the IPv4 service type, time-to-live and header checksum, the UDP checksum, and the reserved byte of the transport header.
- R7: On the last beat only the bytes whose `s_tkeep` bit is set are folded in. That keep pattern must be contiguous from bit 0, and bytes outside it have no effect. Every beat before the last is taken as fully kept.
- R8: For each frame, `crc_valid` or `crc_error` is high for exactly one cycle. The pulse starts at the third rising edge, counting the edge that accepts the last beat as the first, and `crc_value` holds the result during it.
- R9: If the last beat has `s_tkeep` all zero, or a keep pattern that is not contiguous from bit 0, then `crc_error` pulses in place of `crc_valid`. The next frame is handled normally.
- R10: Cycles with `s_tvalid` low between beats of a frame do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tdata | input | 8*BEAT_BYTES | Stream data, byte 0 in bits 7:0 |
| s_tkeep | input | BEAT_BYTES | Byte keep flags |
| s_tvalid | input | 1 | Beat valid |
| s_tlast | input | 1 | Last beat of frame |
| s_tready | output | 1 | Ready, high outside reset |
| crc_value | output | 32 | Invariant CRC of the finished frame |
| crc_valid | output | 1 | One-cycle strobe: `crc_value` is valid |
| crc_error | output | 1 | One-cycle strobe: malformed last-beat keep |

## Verification
The CRC is checked against a bytewise reference for frame lengths whose last beat holds every count from 1 to 64 bytes. This tells apart off-by-one errors in keep handling and shows that unkept filler bytes are ignored. Single-beat frames test the case where the header skip and the last-beat mask fall on the same beat. Back-to-back frames and frames with gaps separate a correct state restart from a correct hold across idle cycles. Frames that differ only in header bytes or in the rewritable fields must give the same CRC, while a change to one payload byte must give a different CRC. Zero-keep and gapped-keep last beats must give the error strobe, and the frame that follows must be handled normally.

// File: rtl/icrc_pkg.sv
package icrc_pkg;

    localparam int          ETH_BYTES  = 14;
    localparam int          IP_BYTES   = 20;
    localparam int          UDP_BYTES  = 8;
    localparam int          LRH_BYTES  = 8;
    localparam logic [31:0] POLY_REFL  = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT   = 32'hFFFFFFFF;

    // Byte offsets from the start of the frame
    localparam int IP_OFS    = ETH_BYTES;
    localparam int UDP_OFS   = IP_OFS + IP_BYTES;
    localparam int BTH_OFS   = UDP_OFS + UDP_BYTES;
    localparam int OFS_TOS   = IP_OFS + 1;
    localparam int OFS_TTL   = IP_OFS + 8;
    localparam int OFS_IPCS  = IP_OFS + 10;
    localparam int OFS_UDPCS = UDP_OFS + 6;
    localparam int OFS_RSV   = BTH_OFS + 4;
    localparam int LAST_MASKED = OFS_RSV;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BODY = 1'b1
    } frame_state_e;

    function automatic logic [31:0] crc_step8(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

    function automatic logic [31:0] lrh_seed();
        logic [31:0] r;
        r = CRC_INIT;
        for (int i = 0; i < LRH_BYTES; i++) begin
            r = crc_step8(r, 8'hFF);
        end
        return r;
    endfunction

    function automatic logic is_variant(input int idx);
        return (idx == OFS_TOS) || (idx == OFS_TTL) ||
               (idx == OFS_IPCS) || (idx == OFS_IPCS + 1) ||
               (idx == OFS_UDPCS) || (idx == OFS_UDPCS + 1) ||
               (idx == OFS_RSV);
    endfunction

endpackage

// File: rtl/icrc_beat_mask.sv
module icrc_beat_mask
    import icrc_pkg::*;
#(
    parameter int BEAT_BYTES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_fire,
    input  logic                    in_first,
    input  logic                    in_last,
    input  logic [8*BEAT_BYTES-1:0] in_data,
    input  logic [BEAT_BYTES-1:0]   in_keep,
    output logic                    s1_vld,
    output logic                    s1_first,
    output logic                    s1_last,
    output logic                    s1_err,
    output logic [8*BEAT_BYTES-1:0] s1_data,
    output logic [BEAT_BYTES-1:0]   s1_en
);

    localparam logic [BEAT_BYTES-1:0] KEEP_ONE = {{(BEAT_BYTES-1){1'b0}}, 1'b1};

    logic [8*BEAT_BYTES-1:0] data_c;
    logic [BEAT_BYTES-1:0]   en_c;
    logic [BEAT_BYTES-1:0]   keep_c;
    logic                    bad_keep;

    // Beats before the last are taken as fully kept
    assign keep_c = in_last ? in_keep : '1;

    for (genvar j = 0; j < BEAT_BYTES; j++) begin : g_byte
        if (j < ETH_BYTES) begin : g_hdr
            assign en_c[j] = keep_c[j] & ~in_first;
        end else begin : g_body
            assign en_c[j] = keep_c[j];
        end
        if (is_variant(j)) begin : g_var
            assign data_c[8*j +: 8] = in_first ? 8'hFF : in_data[8*j +: 8];
        end else begin : g_inv
            assign data_c[8*j +: 8] = in_data[8*j +: 8];
        end
    end

    assign bad_keep = (in_keep == '0) || ((in_keep & (in_keep + KEEP_ONE)) != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_first <= 1'b0;
            s1_last  <= 1'b0;
            s1_err   <= 1'b0;
            s1_data  <= '0;
            s1_en    <= '0;
        end else begin
            s1_vld   <= in_fire;
            s1_first <= in_first;
            s1_last  <= in_last;
            s1_err   <= in_last & bad_keep;
            s1_data  <= data_c;
            s1_en    <= en_c;
        end
    end

endmodule

// File: rtl/icrc_accum.sv
module icrc_accum
    import icrc_pkg::*;
#(
    parameter int BEAT_BYTES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s1_vld,
    input  logic                    s1_first,
    input  logic                    s1_last,
    input  logic                    s1_err,
    input  logic [8*BEAT_BYTES-1:0] s1_data,
    input  logic [BEAT_BYTES-1:0]   s1_en,
    output logic [31:0]             acc_crc,
    output logic                    acc_done,
    output logic                    acc_err
);

    localparam logic [31:0] SEED = lrh_seed();

    logic [31:0] crc_d;

    always_comb begin
        crc_d = s1_first ? SEED : acc_crc;
        for (int j = 0; j < BEAT_BYTES; j++) begin
            if (s1_en[j]) begin
                crc_d = crc_step8(crc_d, s1_data[8*j +: 8]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_crc  <= CRC_INIT;
            acc_done <= 1'b0;
            acc_err  <= 1'b0;
        end else begin
            if (s1_vld) begin
                acc_crc <= crc_d;
            end
            acc_done <= s1_vld & s1_last;
            acc_err  <= s1_vld & s1_last & s1_err;
        end
    end

endmodule

// File: rtl/icrc_gen.sv
module icrc_gen
    import icrc_pkg::*;
#(
    parameter int BEAT_BYTES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [8*BEAT_BYTES-1:0] s_tdata,
    input  logic [BEAT_BYTES-1:0]   s_tkeep,
    input  logic                    s_tvalid,
    input  logic                    s_tlast,
    output logic                    s_tready,
    output logic [31:0]             crc_value,
    output logic                    crc_valid,
    output logic                    crc_error
);

    frame_state_e state_q, state_d;
    logic         ready_q;
    logic         fire;
    logic         s1_vld, s1_first, s1_last, s1_err;
    logic [8*BEAT_BYTES-1:0] s1_data;
    logic [BEAT_BYTES-1:0]   s1_en;
    logic [31:0]  acc_crc;
    logic         acc_done, acc_err;

    assign fire     = s_tvalid & ready_q;
    assign s_tready = ready_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: START, SINGLE and END transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fire && !s_tlast) state_d = ST_BODY;
            ST_BODY: if (fire && s_tlast)  state_d = ST_IDLE;
        endcase
    end

    icrc_beat_mask #(.BEAT_BYTES(BEAT_BYTES)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_fire  (fire),
        .in_first (state_q == ST_IDLE),
        .in_last  (s_tlast),
        .in_data  (s_tdata),
        .in_keep  (s_tkeep),
        .s1_vld   (s1_vld),
        .s1_first (s1_first),
        .s1_last  (s1_last),
        .s1_err   (s1_err),
        .s1_data  (s1_data),
        .s1_en    (s1_en)
    );

    icrc_accum #(.BEAT_BYTES(BEAT_BYTES)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_vld   (s1_vld),
        .s1_first (s1_first),
        .s1_last  (s1_last),
        .s1_err   (s1_err),
        .s1_data  (s1_data),
        .s1_en    (s1_en),
        .acc_crc  (acc_crc),
        .acc_done (acc_done),
        .acc_err  (acc_err)
    );

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q   <= 1'b0;
            crc_value <= '0;
            crc_valid <= 1'b0;
            crc_error <= 1'b0;
        end else begin
            ready_q   <= 1'b1;
            crc_valid <= acc_done & ~acc_err;
            crc_error <= acc_done & acc_err;
            if (acc_done && !acc_err) begin
                crc_value <= ~acc_crc;
            end
        end
    end

endmodule

// File: rtl/icrc_gen_chk.sv
module icrc_gen_chk #(
    parameter int BEAT_BYTES = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [BEAT_BYTES-1:0] s_tkeep,
    input logic                  s_tvalid,
    input logic                  s_tlast,
    input logic                  s_tready,
    input logic                  crc_valid,
    input logic                  crc_error
);

    logic end_beat;
    assign end_beat = s_tvalid && s_tready && s_tlast;

    a_r2_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> s_tready);

    a_r8_from_last: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_valid || crc_error) |-> $past(end_beat, 3));

    a_r8_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $past(end_beat, 3) |-> (crc_valid || crc_error));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_valid && crc_error));

    a_r9_zero_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (end_beat && s_tkeep == '0) |-> ##3 crc_error);

endmodule

bind icrc_gen icrc_gen_chk #(.BEAT_BYTES(BEAT_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_tkeep   (s_tkeep),
    .s_tvalid  (s_tvalid),
    .s_tlast   (s_tlast),
    .s_tready  (s_tready),
    .crc_valid (crc_valid),
    .crc_error (crc_error)
);

// File: tb/sim_icrc_gen.sv
module sim_icrc_gen;

    localparam int BB = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [8*BB-1:0] s_tdata = '0;
    logic [BB-1:0]   s_tkeep = '0;
    logic            s_tvalid = 1'b0;
    logic            s_tlast = 1'b0;
    logic            s_tready;
    logic [31:0]     crc_value;
    logic            crc_valid;
    logic            crc_error;

    always #5 clk = ~clk;

    icrc_gen #(.BEAT_BYTES(BB)) u0 (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tkeep(s_tkeep),
        .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
        .crc_value(crc_value), .crc_valid(crc_valid), .crc_error(crc_error)
    );

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    logic [7:0]  fr [0:511];
    int          out_cyc [0:255];
    logic [31:0] out_crc [0:255];
    bit          out_err [0:255];
    int          exp_cyc [0:255];
    logic [31:0] exp_crc [0:255];
    bit          exp_err [0:255];
    int n_out = 0;
    int n_exp = 0;
    int ptr = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && (crc_valid || crc_error)) begin
            if (n_out < 256) begin
                out_cyc[n_out] = cyc;
                out_crc[n_out] = crc_value;
                out_err[n_out] = crc_error;
            end
            n_out++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog R8: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", msg, act, expv);
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    function automatic logic [31:0] ref_crc(input int len);
        logic [31:0] c;
        logic [7:0]  b;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < 8; i++) c = step(c, 8'hFF);
        for (int i = 14; i < len; i++) begin
            b = (i == 15 || i == 22 || i == 24 || i == 25 ||
                 i == 40 || i == 41 || i == 46) ? 8'hFF : fr[i];
            c = step(c, b);
        end
        return ~c;
    endfunction

    task automatic fill(input int len, input int seed);
        for (int i = 0; i < len; i++) fr[i] = 8'(seed * 37 + i * 11 + (i >> 2));
    endtask

    // bad: 0 normal, 1 zero keep on last beat, 2 keep missing bit 0
    task automatic send(input int len, input bit gaps, input int bad);
        int nb;
        nb = (len + BB - 1) / BB;
        for (int b = 0; b < nb; b++) begin
            if (gaps && b > 0) begin
                @(negedge clk);
                s_tvalid = 1'b0;
                s_tdata  = {BB{8'h5A}};
            end
            @(negedge clk);
            for (int j = 0; j < BB; j++) begin
                s_tdata[8*j +: 8] = (b*BB + j < len) ? fr[b*BB + j] : 8'hC3;
                s_tkeep[j]        = (b*BB + j < len);
            end
            s_tvalid = 1'b1;
            s_tlast  = (b == nb - 1);
            if (b == nb - 1) begin
                if (bad == 1) s_tkeep = '0;
                if (bad == 2) s_tkeep[0] = 1'b0;
                exp_cyc[n_exp] = cyc + 3;
                exp_crc[n_exp] = ref_crc(len);
                exp_err[n_exp] = (bad != 0);
                n_exp++;
            end
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic check_outs(input string tag);
        chk(n_out == n_exp, {tag, " R8 result count"}, n_out, n_exp);
        for (int k = ptr; k < n_exp && k < n_out; k++) begin
            chk(out_cyc[k] == exp_cyc[k], {tag, " R8 result cycle"}, out_cyc[k], exp_cyc[k]);
            chk(out_err[k] == exp_err[k], {tag, " R9 error flag"}, 32'(out_err[k]), 32'(exp_err[k]));
            if (!exp_err[k])
                chk(out_crc[k] == exp_crc[k], {tag, " R3 crc value"}, out_crc[k], exp_crc[k]);
        end
        if (n_out > n_exp) n_exp = n_out;
        n_out = n_exp;
        ptr   = n_exp;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(!crc_valid && !crc_error, "R1 strobes low in reset", {crc_valid, crc_error}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(s_tready == 1'b1, "R1 ready after reset", s_tready, 1);
        chk(!crc_valid && !crc_error, "R1 strobes low after reset", {crc_valid, crc_error}, 0);
    endtask

    task automatic t_keep_sweep;
        for (int k = 1; k <= BB; k++) begin
            fill(128 + k, k);
            send(128 + k, 1'b0, 0);
            idle(5);
            check_outs($sformatf("R7 R5 last beat %0d bytes", k));
        end
    endtask

    task automatic t_single_beat;
        int lens [3] = '{54, 60, 64};
        foreach (lens[i]) begin
            fill(lens[i], 90 + i);
            send(lens[i], 1'b0, 0);
            idle(5);
            check_outs($sformatf("R4 single beat len %0d", lens[i]));
        end
    endtask

    task automatic t_back_to_back;
        fill(150, 3);  send(150, 1'b0, 0);
        fill(64, 4);   send(64, 1'b0, 0);
        fill(257, 5);  send(257, 1'b0, 0);
        idle(6);
        check_outs("R2 back to back");
    endtask

    task automatic t_gaps;
        fill(230, 7);
        send(230, 1'b1, 0);
        idle(6);
        check_outs("R10 idle gaps");
    endtask

    task automatic t_invariance;
        logic [31:0] base;
        fill(100, 11);
        send(100, 1'b0, 0); idle(5); check_outs("R3 base frame");
        base = out_crc[ptr - 1];
        fr[3] ^= 8'hFF; fr[12] ^= 8'h0F; fr[15] ^= 8'h55; fr[22] ^= 8'h01;
        fr[25] ^= 8'hA0; fr[40] ^= 8'h33; fr[46] ^= 8'h80;
        send(100, 1'b0, 0); idle(5); check_outs("R6 masked fields");
        chk(out_crc[ptr - 1] == base, "R4 R6 header and variant bytes ignored", out_crc[ptr - 1], base);
        fr[70] ^= 8'h01;
        send(100, 1'b0, 0); idle(5); check_outs("R3 payload change");
        chk(out_crc[ptr - 1] != base, "R3 payload byte changes crc", out_crc[ptr - 1], ~base);
    endtask

    task automatic t_bad_keep;
        fill(130, 21);
        send(130, 1'b0, 1);
        send(130, 1'b0, 2);
        fill(140, 22);
        send(140, 1'b0, 0);
        idle(6);
        check_outs("R9 bad keep then good frame");
    endtask

    initial begin
        t_reset();
        t_keep_sweep();
        t_single_beat();
        t_back_to_back();
        t_gaps();
        t_invariance();
        t_bad_keep();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule